// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor

A small programmable processor built from a controller state machine and a datapath. The controller owns the program counter, the instruction register and an instruction memory. The datapath holds a sixteen-entry register file with two read ports and one write port, a 256-word data memory, an ALU that can pass, add or subtract, a three-way write-back selector and an all-zeros detector on the first read port. Every instruction takes one Fetch cycle, one Decode cycle and one execute cycle that the opcode selects. After reset the machine spends one cycle in Init before its first Fetch.

Programs and initial data are written through a preload port while reset is held. The register-file and data-memory write strobes, with their addresses and data, are brought out as outputs, and so is the program counter. A surrounding system or a bench can therefore follow every architectural write and the exact cycle in which it lands.

Instructions are 16 bits. Bits 15:12 hold the opcode and bits 11:8 hold the destination or tested register `ra`. Bits 7:4 and 3:0 hold the source registers `rb` and `rc`. Bits 7:0 also serve as the memory address, the constant or the jump offset, depending on the opcode. A taken jump adds the sign-extended offset to the already incremented PC and then takes one away. The next fetch therefore comes from the jump's own address plus the offset.

Top module: `proc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the state is forced to Init, `pc` is 0 and neither write strobe is asserted. After release the machine spends one cycle in Init and then fetches from address 0.
- R2: Each instruction takes exactly three cycles. Call the cycle after the first edge with reset low cycle 1. Instruction n in execution order then has its Fetch in cycle 3n+1, its Decode in cycle 3n+2 and its execute in cycle 3n+3. The write strobes are asserted only during an execute cycle, and never both at once.
- R3: Opcode 0000 (load) writes data memory word `ir[7:0]` into register `ir[11:8]`.
- R4: Opcode 0001 (store) writes register `ir[11:8]` to data memory word `ir[7:0]`. A later load from that word returns the stored value.
- R5: Opcode 0010 (add) writes `R[ir[7:4]] + R[ir[3:0]]`, modulo 2^16, into register `ir[11:8]`.
- R6: Opcode 0011 (load constant) writes `ir[7:0]` zero-extended to 16 bits into register `ir[11:8]`.
- R7: Opcode 0100 (subtract) writes `R[ir[7:4]] - R[ir[3:0]]`, modulo 2^16, into register `ir[11:8]`.
- R8: Opcode 0101 (jump if zero) tests register `ir[11:8]`. If it is zero, the next fetch comes from the jump's own address plus `ir[7:0]` taken as a signed byte, modulo the instruction-memory depth. Otherwise the next fetch comes from the following address. An offset of 0 makes a self-loop. The jump writes nothing.
- R9: Opcodes 0110 to 1111 write neither the register file nor the data memory, and they still take three cycles.
- R10: With `loadEn` high, `loadAddr`/`loadData` write the instruction memory when `loadToData` is 0 and the data memory when `loadToData` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to Init |
| loadEn | input | 1 | Preload write strobe |
| loadToData | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| loadAddr | input | 8 | Preload word address |
| loadData | input | 16 | Preload word |
| pc | output | PcW (6 by default) | Program counter |
| rfWrEn | output | 1 | Register-file write strobe, execute cycle only |
| rfWrAddr | output | 4 | Register being written |
| rfWrData | output | 16 | Value being written to the register |
| memWrEn | output | 1 | Data-memory write strobe, execute cycle only |
| memWrAddr | output | 8 | Data-memory word being written |
| memWrData | output | 16 | Value being written to memory |

## Verification
Every result of this block is a write strobe, and it is due in the execute cycle: exactly two cycles after that instruction's Fetch, with fetches three cycles apart from cycle 1 after reset release. A bench reference model walks the program in execution order, taking jumps and undefined opcodes into account. It tags each expected write with its cycle number, and the monitor checks the cycle as well as the target and the value. A wrong jump target, a lost cycle or a spurious write in a Decode or no-op cycle therefore shifts or adds a strobe and is caught at the first write that follows. Reset state is sampled while reset is held, just before release.

// File: rtl/proc_pkg.sv
package proc_pkg;

  localparam int WORD_W  = 16;
  localparam int OP_W    = 4;
  localparam int REG_AW  = 4;
  localparam int MEM_AW  = 8;
  localparam int FIELD_W = 8;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'h0;
  localparam logic [OP_W-1:0] OP_STORE = 4'h1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h2;
  localparam logic [OP_W-1:0] OP_CONST = 4'h3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OP_JZ    = 4'h5;

  typedef enum logic [3:0] {
    ST_INIT, ST_FETCH, ST_DECODE,
    ST_LOAD, ST_STORE, ST_ADD, ST_CONST, ST_SUB, ST_JUMP, ST_NOP
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'b00,
    ALU_ADD  = 2'b01,
    ALU_SUB  = 2'b10
  } alu_sel_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'b00,
    WB_MEM = 2'b01,
    WB_IMM = 2'b10
  } wb_sel_e;

  typedef struct packed {
    logic [REG_AW-1:0]  rpAddr;
    logic [REG_AW-1:0]  rqAddr;
    logic [REG_AW-1:0]  wAddr;
    logic               rfWr;
    wb_sel_e            wbSel;
    alu_sel_e           aluSel;
    logic [MEM_AW-1:0]  dAddr;
    logic               memWr;
    logic [FIELD_W-1:0] imm;
  } ctl_t;

endpackage

// File: rtl/proc_regfile.sv
module proc_regfile
  import proc_pkg::*;
#(
  parameter int AddrW = REG_AW,
  parameter int Width = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AddrW-1:0] wAddr,
  input  logic [Width-1:0] wData,
  input  logic [AddrW-1:0] rpAddr,
  input  logic [AddrW-1:0] rqAddr,
  output logic [Width-1:0] rpData,
  output logic [Width-1:0] rqData
);

  localparam int Words = 1 << AddrW;

  logic [Width-1:0] regs [Words];

  for (genvar i = 0; i < Words; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr && (wAddr == AddrW'(i))) regs[i] <= wData;
    end
  end

  assign rpData = regs[rpAddr];
  assign rqData = regs[rqAddr];

  AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr |=> (regs[$past(wAddr)] == $past(wData))); // R3

endmodule

// File: rtl/proc_alu.sv
module proc_alu
  import proc_pkg::*;
#(
  parameter int Width = WORD_W
) (
  input  logic [Width-1:0] a,
  input  logic [Width-1:0] b,
  input  alu_sel_e         sel,
  output logic [Width-1:0] y
);

  always_comb begin
    case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/proc_dpath.sv
module proc_dpath
  import proc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  ctl_t              ctl,
  output logic              rpZero,
  output logic [WORD_W-1:0] wbData,
  output logic [WORD_W-1:0] storeData
);

  localparam int MemDepth = 1 << MEM_AW;

  logic [WORD_W-1:0] rpData, rqData, aluOut, memRd;
  logic [WORD_W-1:0] dmem [MemDepth];

  proc_regfile #(.AddrW(REG_AW), .Width(WORD_W)) u_rf (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctl.rfWr),
    .wAddr  (ctl.wAddr),
    .wData  (wbData),
    .rpAddr (ctl.rpAddr),
    .rqAddr (ctl.rqAddr),
    .rpData (rpData),
    .rqData (rqData)
  );

  proc_alu #(.Width(WORD_W)) u_alu (
    .a   (rpData),
    .b   (rqData),
    .sel (ctl.aluSel),
    .y   (aluOut)
  );

  always_ff @(posedge clk) begin
    if (loadEn && loadToData) dmem[loadAddr] <= loadData;
    else if (ctl.memWr)       dmem[ctl.dAddr] <= rpData;
  end

  assign memRd = dmem[ctl.dAddr];

  always_comb begin
    case (ctl.wbSel)
      WB_MEM:  wbData = memRd;
      WB_IMM:  wbData = WORD_W'(ctl.imm);
      default: wbData = aluOut;
    endcase
  end

  assign rpZero    = ~|rpData;
  assign storeData = rpData;

  AST_MEM_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (ctl.memWr && !loadEn) |=> (dmem[$past(ctl.dAddr)] == $past(rpData))); // R4

  AST_SUB_INVERTS: assert property (@(posedge clk) disable iff (rst)
    (ctl.rfWr && ctl.aluSel == ALU_SUB) |-> ((wbData + rqData) == rpData)); // R7

  AST_CONST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (ctl.rfWr && ctl.wbSel == WB_IMM) |-> (wbData[WORD_W-1:FIELD_W] == '0)); // R6

endmodule

// File: rtl/proc_ctrl.sv
module proc_ctrl
  import proc_pkg::*;
#(
  parameter  int ImemDepth = 64,
  localparam int PcW       = $clog2(ImemDepth)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  input  logic              rpZero,
  output ctl_t              ctl,
  output logic [PcW-1:0]    pc
);

  logic [WORD_W-1:0] imem [ImemDepth];
  logic [WORD_W-1:0] ir;
  logic [PcW-1:0]    pcReg, pcNext, jumpOff, jumpTarget;
  logic [WORD_W-1:0] offExt;
  state_e            state, nextState, execState;

  logic [OP_W-1:0]    op;
  logic [REG_AW-1:0]  ra, rb, rc;
  logic [FIELD_W-1:0] dField;

  assign op     = ir[15:12];
  assign ra     = ir[11:8];
  assign rb     = ir[7:4];
  assign rc     = ir[3:0];
  assign dField = ir[7:0];

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData && (int'(loadAddr) < ImemDepth))
      imem[loadAddr[PcW-1:0]] <= loadData;
  end

  assign offExt     = {{(WORD_W-FIELD_W){dField[FIELD_W-1]}}, dField};
  assign jumpOff    = offExt[PcW-1:0];
  assign jumpTarget = pcReg + jumpOff - PcW'(1);

  always_comb begin
    case (op)
      OP_LOAD:  execState = ST_LOAD;
      OP_STORE: execState = ST_STORE;
      OP_ADD:   execState = ST_ADD;
      OP_CONST: execState = ST_CONST;
      OP_SUB:   execState = ST_SUB;
      OP_JZ:    execState = ST_JUMP;
      default:  execState = ST_NOP;
    endcase
  end

  always_comb begin
    nextState = ST_FETCH;
    pcNext    = pcReg;
    case (state)
      ST_INIT:   pcNext = '0;
      ST_FETCH: begin
        nextState = ST_DECODE;
        pcNext    = pcReg + PcW'(1);
      end
      ST_DECODE: nextState = execState;
      ST_JUMP:   if (rpZero) pcNext = jumpTarget;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_INIT;
      pcReg <= '0;
      ir    <= '0;
    end else begin
      state <= nextState;
      pcReg <= pcNext;
      if (state == ST_FETCH) ir <= imem[pcReg];
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.aluSel = ALU_PASS;
    ctl.wbSel  = WB_ALU;
    ctl.rpAddr = ra;
    ctl.rqAddr = rc;
    ctl.wAddr  = ra;
    ctl.dAddr  = dField;
    ctl.imm    = dField;
    case (state)
      ST_LOAD: begin
        ctl.rfWr  = 1'b1;
        ctl.wbSel = WB_MEM;
      end
      ST_STORE: ctl.memWr = 1'b1;
      ST_ADD: begin
        ctl.rpAddr = rb;
        ctl.aluSel = ALU_ADD;
        ctl.rfWr   = 1'b1;
      end
      ST_SUB: begin
        ctl.rpAddr = rb;
        ctl.aluSel = ALU_SUB;
        ctl.rfWr   = 1'b1;
      end
      ST_CONST: begin
        ctl.wbSel = WB_IMM;
        ctl.rfWr  = 1'b1;
      end
      default: ;
    endcase
  end

  assign pc = pcReg;

  AST_INIT_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == ST_INIT)); // R1

  AST_INIT_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT) |=> (state == ST_FETCH && pcReg == '0)); // R1

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_DECODE && pcReg == PcW'($past(pcReg) + PcW'(1)))); // R2

  AST_EXEC_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_LOAD, ST_STORE, ST_ADD, ST_CONST, ST_SUB, ST_JUMP, ST_NOP})
      |=> (state == ST_FETCH)); // R2

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(ctl.rfWr && ctl.memWr)); // R2

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_JUMP && rpZero)
      |=> (pcReg == PcW'($past(pcReg) + $past(jumpOff) - PcW'(1)))); // R8

  AST_JUMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_JUMP && !rpZero) |=> $stable(pcReg)); // R8

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NOP) |-> (!ctl.rfWr && !ctl.memWr)); // R9

endmodule

// File: rtl/proc_core.sv
module proc_core
  import proc_pkg::*;
#(
  parameter  int ImemDepth = 64,
  localparam int PcW       = $clog2(ImemDepth)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [WORD_W-1:0] loadData,
  output logic [PcW-1:0]    pc,
  output logic              rfWrEn,
  output logic [REG_AW-1:0] rfWrAddr,
  output logic [WORD_W-1:0] rfWrData,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memWrAddr,
  output logic [WORD_W-1:0] memWrData
);

  ctl_t ctl;
  logic rpZero;

  proc_ctrl #(.ImemDepth(ImemDepth)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .rpZero     (rpZero),
    .ctl        (ctl),
    .pc         (pc)
  );

  proc_dpath u_dpath (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .ctl        (ctl),
    .rpZero     (rpZero),
    .wbData     (rfWrData),
    .storeData  (memWrData)
  );

  assign rfWrEn    = ctl.rfWr;
  assign rfWrAddr  = ctl.wAddr;
  assign memWrEn   = ctl.memWr;
  assign memWrAddr = ctl.dAddr;

endmodule

// File: tb/proc_core_tb.sv
`timescale 1ns/1ps
module proc_core_tb;

  localparam int ImemDepth = 64;
  localparam int PcW       = $clog2(ImemDepth);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst = 1'b1;
  logic           loadEn = 1'b0, loadToData = 1'b0;
  logic [7:0]     loadAddr = '0;
  logic [15:0]    loadData = '0;
  logic [PcW-1:0] pc;
  logic           rfWrEn, memWrEn;
  logic [3:0]     rfWrAddr;
  logic [7:0]     memWrAddr;
  logic [15:0]    rfWrData, memWrData;

  proc_core #(.ImemDepth(ImemDepth)) u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadData(loadData), .pc(pc),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  int    testsRun = 0, testsFailed = 0;
  int    cyc = 0;
  bit    runActive = 1'b0;
  string curTest = "";

  logic [15:0] progMem [ImemDepth];
  logic [15:0] dataInit [256];

  typedef struct packed {
    int          cyc;
    logic        isMem;
    logic [7:0]  addr;
    logic [15:0] data;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, curTest, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] ra,
                                      input logic [7:0] low);
    return {op, ra, low};
  endfunction
  function automatic logic [15:0] iLd (input int ra, input int d) ;  return enc(4'h0, 4'(ra), 8'(d)); endfunction
  function automatic logic [15:0] iSt (input int ra, input int d) ;  return enc(4'h1, 4'(ra), 8'(d)); endfunction
  function automatic logic [15:0] iAdd(input int ra, input int rb, input int rc); return enc(4'h2, 4'(ra), {4'(rb), 4'(rc)}); endfunction
  function automatic logic [15:0] iLdc(input int ra, input int c) ;  return enc(4'h3, 4'(ra), 8'(c)); endfunction
  function automatic logic [15:0] iSub(input int ra, input int rb, input int rc); return enc(4'h4, 4'(ra), {4'(rb), 4'(rc)}); endfunction
  function automatic logic [15:0] iJz (input int ra, input int off); return enc(4'h5, 4'(ra), 8'(off)); endfunction

  // Monitor: every write strobe is compared with the head of the scoreboard
  always @(negedge clk) begin
    if (runActive && (rfWrEn || memWrEn)) begin
      if (rfWrEn && memWrEn)
        check(1'b0, "R2", "both write strobes high", 1, 0);
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R9", "unexpected write in cycle", cyc, -1);
      end else begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(cyc == e.cyc, "R2", "write cycle", cyc, e.cyc);
        if (memWrEn) begin
          check(e.isMem && memWrAddr == e.addr, t, "memory target (1=mem,addr)",
                {1'b1, memWrAddr}, {e.isMem, e.addr});
          check(memWrData == e.data, t, "memory write data", memWrData, e.data);
        end else begin
          check(!e.isMem && rfWrAddr == e.addr[3:0], t, "register target (1=mem,addr)",
                {5'b0, rfWrAddr}, {e.isMem, e.addr});
          check(rfWrData == e.data, t, "register write data", rfWrData, e.data);
        end
      end
    end
  end

  // Reference model of the instruction set, built from the requirements
  task automatic buildExpect(output int endCycle);
    logic [15:0] rf [16];
    logic [15:0] dm [256];
    int pcM = 0, c = 1, steps = 0;
    bit halted = 1'b0;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) dm[i] = dataInit[i];
    while (!halted && steps < 400) begin
      logic [15:0] w;
      int a, ex, ra, rb, rc, d;
      w  = progMem[pcM];
      a  = pcM;
      pcM = (pcM + 1) % ImemDepth;
      ex = c + 2;
      ra = int'(w[11:8]); rb = int'(w[7:4]); rc = int'(w[3:0]); d = int'(w[7:0]);
      case (w[15:12])
        4'h0: begin rf[ra] = dm[d];                 expQ.push_back('{ex, 1'b0, 8'(ra), rf[ra]}); tagQ.push_back("R3"); end
        4'h1: begin dm[d] = rf[ra];                 expQ.push_back('{ex, 1'b1, 8'(d), rf[ra]});  tagQ.push_back("R4"); end
        4'h2: begin rf[ra] = rf[rb] + rf[rc];       expQ.push_back('{ex, 1'b0, 8'(ra), rf[ra]}); tagQ.push_back("R5"); end
        4'h3: begin rf[ra] = {8'h00, w[7:0]};       expQ.push_back('{ex, 1'b0, 8'(ra), rf[ra]}); tagQ.push_back("R6"); end
        4'h4: begin rf[ra] = rf[rb] - rf[rc];       expQ.push_back('{ex, 1'b0, 8'(ra), rf[ra]}); tagQ.push_back("R7"); end
        4'h5: begin
          if (rf[ra] == 16'h0) begin
            int o, np;
            o  = int'($signed(w[7:0]));
            np = ((a + o) % ImemDepth + ImemDepth) % ImemDepth;
            if (np == a) halted = 1'b1;
            pcM = np;
          end
        end
        default: ;
      endcase
      c += 3;
      steps++;
    end
    endCycle = c + 6;
  endtask

  task automatic runTest(input string name);
    int endC;
    curTest = name;
    rst = 1'b1;
    @(negedge clk);
    loadEn = 1'b1;
    loadToData = 1'b0;
    for (int i = 0; i < ImemDepth; i++) begin
      loadAddr = 8'(i); loadData = progMem[i]; @(negedge clk);
    end
    loadToData = 1'b1;
    for (int i = 0; i < 256; i++) begin
      loadAddr = 8'(i); loadData = dataInit[i]; @(negedge clk);
    end
    loadEn = 1'b0;
    @(negedge clk);
    check(pc == '0, "R1", "pc while in reset", int'(pc), 0);
    check(!rfWrEn && !memWrEn, "R1", "write strobes while in reset",
          {rfWrEn, memWrEn}, 0);
    buildExpect(endC);
    rst = 1'b0;
    runActive = 1'b1;
    while (cyc < endC) @(negedge clk);
    runActive = 1'b0;
    check(expQ.size() == 0, "R2", "expected writes never seen", expQ.size(), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  task automatic clearImages();
    for (int i = 0; i < ImemDepth; i++) progMem[i] = 16'hF000;
    for (int i = 0; i < 256; i++) dataInit[i] = 16'h0000;
  endtask

  initial begin
    // R10 preload and R3 R4 R5: D9 = D0 + D1 in raw machine words
    clearImages();
    dataInit[0] = 16'd99; dataInit[1] = 16'd102;
    progMem[0] = 16'h0000; progMem[1] = 16'h0101;
    progMem[2] = 16'h2201; progMem[3] = 16'h1209;
    progMem[4] = iLdc(15, 0); progMem[5] = iJz(15, 0);
    runTest("R10_sum");

    // R6 R7 R5 wrap-around, store then reload R4
    clearImages();
    dataInit[2] = 16'hFFFF; dataInit[3] = 16'h0002; dataInit[255] = 16'h1234;
    progMem[0]  = iLdc(3, 8'hFF);
    progMem[1]  = iLdc(4, 1);
    progMem[2]  = iSub(5, 4, 3);
    progMem[3]  = iLd(6, 2);
    progMem[4]  = iLd(7, 3);
    progMem[5]  = iAdd(8, 6, 7);
    progMem[6]  = iSub(9, 7, 7);
    progMem[7]  = iSt(5, 20);
    progMem[8]  = iSt(8, 21);
    progMem[9]  = iLdc(10, 8'h80);
    progMem[10] = iSt(10, 255);
    progMem[11] = iLd(11, 255);
    progMem[12] = iLdc(0, 0);
    progMem[13] = iJz(0, 0);
    runTest("R6_R7_arith");

    // R8 taken and not-taken jumps, forward and backward
    clearImages();
    dataInit[4] = 16'd7; dataInit[5] = 16'd0;
    progMem[0]  = iLdc(1, 0);
    progMem[1]  = iLdc(2, 1);
    progMem[2]  = iLd(3, 4);
    progMem[3]  = iJz(3, 2);
    progMem[4]  = iAdd(1, 1, 2);
    progMem[5]  = iLd(3, 5);
    progMem[6]  = iJz(3, 2);
    progMem[7]  = iAdd(1, 1, 2);
    progMem[8]  = iSt(1, 9);
    progMem[9]  = iLdc(4, 3);
    progMem[10] = iSub(4, 4, 2);
    progMem[11] = iJz(4, 3);
    progMem[12] = iLdc(0, 0);
    progMem[13] = iJz(0, -3);
    progMem[14] = iSt(4, 10);
    progMem[15] = iLdc(0, 0);
    progMem[16] = iJz(0, 0);
    runTest("R8_branch");

    // R9 undefined opcodes: no writes, three cycles each
    clearImages();
    progMem[0] = iLdc(1, 5);
    progMem[1] = 16'h6123;
    progMem[2] = 16'hF0FF;
    progMem[3] = iLdc(2, 6);
    progMem[4] = 16'h7777;
    progMem[5] = iAdd(3, 1, 2);
    progMem[6] = 16'hA209;
    progMem[7] = iSt(3, 30);
    progMem[8] = iLdc(0, 0);
    progMem[9] = iJz(0, 0);
    runTest("R9_undef");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog [%s] run did not finish actual=%0d expected=%0d", curTest, cyc, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule